// File: doc/BRIEF.md
# Serial Time Slot Programming Interface

This block accepts 8-bit control words on a serial line, clocked by a control clock and framed by an active-low chip select. Each completed word carries two direction bits and a 6-bit slot number, sent most significant bit first. Channel select pins and a mode pin are captured alongside the final data bit. A bank of eight per-output slot registers is then updated: four transmit sync outputs (indices 0 to 3) and four receive sync outputs (indices 4 to 7). Each register holds an enable flag and a slot number.

In the bidirectional mode (mode pin high), the low two channel bits pick one channel. The direction bits then pick its transmit register, its receive register, or both. In the unidirectional mode (mode pin low), all three channel bits pick one of the eight registers directly, and one direction code turns that register off. A later block reads the register bank and uses it to place the frame sync pulses.

Top module: `tslot_ctl_top`

## Requirements
- R1: After reset, every output enable in `fs_en` is 0 and every slot field in `fs_slot` is 0.
- R2: While `cs_n` is low, each rising `ctl_clk` edge shifts in one bit from `sdi`. The first bit is X, the second is R, and then the slot bits follow from bit 5 down to bit 0.
- R3: A word takes effect on the first rising `ctl_clk` edge that sees `cs_n` high after exactly 8 bits. The register outputs stay unchanged while `cs_n` is low.
- R4: A frame of any length other than 8 bits (0, fewer than 8, or more than 8) is discarded and changes no register.
- R5: In mode 1 (`mode_sel`=1), `ch_sel[1:0]`=c selects channel c. Its transmit register is index c and its receive register is index 4+c. `ch_sel[2]` is ignored.
- R6: In mode 1, the direction code {X,R} decides which registers are written: 01 writes transmit only, 10 writes receive only, and 00 or 11 write both. Every register written is enabled and takes the slot number.
- R7: In mode 2 (`mode_sel`=0), `ch_sel[2:0]`=n selects register index n. Codes 0 to 3 are transmit syncs 0 to 3, and codes 4 to 7 are receive syncs 0 to 3. If {X,R} is not 11, that register is enabled and takes the slot number.
- R8: In mode 2, {X,R}=11 clears the enable of the selected register and leaves its slot field unchanged.
- R9: `ch_sel` and `mode_sel` are sampled on the edge that takes the eighth bit. Changes after that edge have no effect on the word.
- R10: A committed word changes no register other than the ones it selects.
- R11: Every slot number from 0 to 63 is stored exactly. Register n occupies `fs_slot[6n+5:6n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock; data shifts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low word frame |
| sdi | input | 1 | Serial control data |
| ch_sel | input | 3 | Channel / output select |
| mode_sel | input | 1 | 1 = paired transmit/receive mode, 0 = eight independent outputs |
| fs_en | output | 8 | Enable flag per sync output (0-3 transmit, 4-7 receive) |
| fs_slot | output | 48 | Slot number per sync output, 6 bits each |

## Verification
The bench builds the block with its default parameters: a 6-bit slot, four channels per direction, and so eight registers. At this size every combination of channel code, mode and direction code can be swept exhaustively, and so can every slot value on one register. All eight registers are compared against an arithmetic model after every frame. Frame lengths of 0, 1, 7, 9 and 12 bits, and select pins that change after the last bit, cover the discard and sampling rules.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

   // Direction code carried in the two leading bits of a word ({X,R})
   typedef enum logic [1:0] {
      DIR_PAIR_A = 2'b00,
      DIR_TX     = 2'b01,
      DIR_RX     = 2'b10,
      DIR_PAIR_B = 2'b11
   } dir_code_e;

   // In the unidirectional mode the paired code means "turn off"
   localparam dir_code_e DIR_OFF = DIR_PAIR_B;

endpackage

// File: rtl/tslot_shift.sv
module tslot_shift #(
   parameter int WORD_W = 8,
   parameter int CH_W   = 3,
   localparam int CNT_W = $clog2(WORD_W + 2)
) (
   input  logic              ctl_clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic [CH_W-1:0]   ch_sel,
   input  logic              mode_sel,
   output logic [WORD_W-1:0] word_q,
   output logic [CH_W-1:0]   ch_q,
   output logic              mode_q,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              commit
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         ch_q    <= '0;
         mode_q  <= 1'b1;
         bit_cnt <= '0;
      end else if (!cs_n) begin
         word_q <= {word_q[WORD_W-2:0], sdi};
         if (bit_cnt != CNT_OVER) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (bit_cnt == CNT_LAST) begin
            ch_q   <= ch_sel;
            mode_q <= mode_sel;
         end
      end else begin
         bit_cnt <= '0;
      end
   end

   // A frame closes on the first edge with the select released
   assign commit = cs_n && (bit_cnt == CNT_FULL);

endmodule

// File: rtl/tslot_decode.sv
module tslot_decode
   import tslot_pkg::*;
#(
   parameter int SLOT_W     = 6,
   parameter int CH_PER_DIR = 4,
   localparam int WORD_W    = SLOT_W + 2,
   localparam int NUM_OUT   = 2 * CH_PER_DIR,
   localparam int CH_W      = $clog2(NUM_OUT)
) (
   input  logic [WORD_W-1:0]  word_q,
   input  logic [CH_W-1:0]    ch_q,
   input  logic               mode_q,
   input  logic               commit,
   output logic [NUM_OUT-1:0] wr_mask,
   output logic [SLOT_W-1:0]  wr_slot,
   output logic               wr_en,
   output dir_code_e          dir
);

   logic [CH_W-1:0] tx_idx;
   logic [CH_W-1:0] rx_idx;

   assign dir     = dir_code_e'(word_q[WORD_W-1 -: 2]);
   assign wr_slot = word_q[SLOT_W-1:0];
   assign tx_idx  = {1'b0, ch_q[CH_W-2:0]};
   assign rx_idx  = {1'b1, ch_q[CH_W-2:0]};

   always_comb begin
      wr_mask = '0;
      wr_en   = 1'b1;
      if (commit) begin
         if (mode_q) begin
            unique case (dir)
               DIR_TX:  wr_mask[tx_idx] = 1'b1;
               DIR_RX:  wr_mask[rx_idx] = 1'b1;
               default: begin
                  wr_mask[tx_idx] = 1'b1;
                  wr_mask[rx_idx] = 1'b1;
               end
            endcase
         end else begin
            wr_mask[ch_q] = 1'b1;
            wr_en         = (dir != DIR_OFF);
         end
      end
   end

endmodule

// File: rtl/tslot_bank.sv
module tslot_bank #(
   parameter int SLOT_W  = 6,
   parameter int NUM_OUT = 8
) (
   input  logic                      ctl_clk,
   input  logic                      rst_n,
   input  logic [NUM_OUT-1:0]        wr_mask,
   input  logic [SLOT_W-1:0]         wr_slot,
   input  logic                      wr_en,
   output logic [NUM_OUT-1:0]        fs_en,
   output logic [NUM_OUT*SLOT_W-1:0] fs_slot
);

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_reg
      always_ff @(posedge ctl_clk or negedge rst_n) begin
         if (!rst_n) begin
            fs_en[g]                    <= 1'b0;
            fs_slot[g*SLOT_W +: SLOT_W] <= '0;
         end else if (wr_mask[g]) begin
            fs_en[g] <= wr_en;
            if (wr_en) begin
               fs_slot[g*SLOT_W +: SLOT_W] <= wr_slot;
            end
         end
      end
   end

endmodule

// File: rtl/tslot_ctl_top.sv
module tslot_ctl_top
   import tslot_pkg::*;
#(
   parameter int SLOT_W     = 6,
   parameter int CH_PER_DIR = 4,
   localparam int WORD_W    = SLOT_W + 2,
   localparam int NUM_OUT   = 2 * CH_PER_DIR,
   localparam int CH_W      = $clog2(NUM_OUT),
   localparam int CNT_W     = $clog2(WORD_W + 2)
) (
   input  logic                      ctl_clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      sdi,
   input  logic [CH_W-1:0]           ch_sel,
   input  logic                      mode_sel,
   output logic [NUM_OUT-1:0]        fs_en,
   output logic [NUM_OUT*SLOT_W-1:0] fs_slot
);

   if (SLOT_W < 1) begin : g_bad_slot
      $error("tslot_ctl_top: SLOT_W must be at least 1");
   end
   if (CH_PER_DIR < 2 || (CH_PER_DIR & (CH_PER_DIR - 1)) != 0) begin : g_bad_ch
      $error("tslot_ctl_top: CH_PER_DIR must be a power of two, at least 2");
   end

   logic [WORD_W-1:0]  word_q;
   logic [CH_W-1:0]    ch_q;
   logic               mode_q;
   logic [CNT_W-1:0]   bit_cnt;
   logic               commit;
   logic [NUM_OUT-1:0] wr_mask;
   logic [SLOT_W-1:0]  wr_slot;
   logic               wr_en;
   dir_code_e          dir;

   tslot_shift #(.WORD_W(WORD_W), .CH_W(CH_W)) u_shift (
      .ctl_clk (ctl_clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .sdi     (sdi),
      .ch_sel  (ch_sel),
      .mode_sel(mode_sel),
      .word_q  (word_q),
      .ch_q    (ch_q),
      .mode_q  (mode_q),
      .bit_cnt (bit_cnt),
      .commit  (commit)
   );

   tslot_decode #(.SLOT_W(SLOT_W), .CH_PER_DIR(CH_PER_DIR)) u_decode (
      .word_q (word_q),
      .ch_q   (ch_q),
      .mode_q (mode_q),
      .commit (commit),
      .wr_mask(wr_mask),
      .wr_slot(wr_slot),
      .wr_en  (wr_en),
      .dir    (dir)
   );

   tslot_bank #(.SLOT_W(SLOT_W), .NUM_OUT(NUM_OUT)) u_bank (
      .ctl_clk(ctl_clk),
      .rst_n  (rst_n),
      .wr_mask(wr_mask),
      .wr_slot(wr_slot),
      .wr_en  (wr_en),
      .fs_en  (fs_en),
      .fs_slot(fs_slot)
   );

endmodule

// File: rtl/tslot_ctl_chk.sv
module tslot_ctl_chk
   import tslot_pkg::*;
#(
   parameter int SLOT_W  = 6,
   parameter int NUM_OUT = 8,
   parameter int WORD_W  = 8,
   parameter int CNT_W   = 4
) (
   input logic                      ctl_clk,
   input logic                      rst_n,
   input logic                      cs_n,
   input logic [NUM_OUT-1:0]        fs_en,
   input logic [NUM_OUT*SLOT_W-1:0] fs_slot,
   input logic [CNT_W-1:0]          bit_cnt,
   input logic                      commit,
   input logic                      mode_q,
   input logic [NUM_OUT-1:0]        wr_mask,
   input logic                      wr_en,
   input dir_code_e                 dir
);

   always @(posedge ctl_clk) begin
      if (rst_n) begin
         AST_CNT_BOUND: assert (bit_cnt <= CNT_W'(WORD_W + 1)); // R2
      end
   end

   AST_HOLD_WHILE_FRAMED: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      !cs_n |=> ($stable(fs_en) && $stable(fs_slot))); // R3

   AST_DISCARD_BAD_LEN: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (cs_n && !commit) |=> ($stable(fs_en) && $stable(fs_slot))); // R4

   AST_PAIR_WRITE: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (commit && mode_q && (dir == DIR_PAIR_A || dir == DIR_PAIR_B))
      |-> ($countones(wr_mask) == 2)); // R6

   AST_SINGLE_WRITE: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (commit && !mode_q) |-> ($countones(wr_mask) == 1)); // R7

   AST_OFF_CLEARS: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (commit && !wr_en) |=> ((fs_en & $past(wr_mask)) == '0)); // R8

endmodule

bind tslot_ctl_top tslot_ctl_chk #(
   .SLOT_W (SLOT_W),
   .NUM_OUT(NUM_OUT),
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W)
) u_chk (
   .ctl_clk(ctl_clk),
   .rst_n  (rst_n),
   .cs_n   (cs_n),
   .fs_en  (fs_en),
   .fs_slot(fs_slot),
   .bit_cnt(bit_cnt),
   .commit (commit),
   .mode_q (mode_q),
   .wr_mask(wr_mask),
   .wr_en  (wr_en),
   .dir    (dir)
);

// File: tb/tslot_ctl_top_bench.sv
module tslot_ctl_top_bench;

   logic        ctl_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic        cs_n    = 1'b1;
   logic        sdi     = 1'b0;
   logic [2:0]  ch_sel  = 3'd0;
   logic        mode_sel = 1'b1;
   logic [7:0]  fs_en;
   logic [47:0] fs_slot;

   int checks = 0;
   int errors = 0;

   logic       exp_en   [8];
   logic [5:0] exp_slot [8];

   always #10ns ctl_clk = ~ctl_clk;

   tslot_ctl_top u_tslot_ctl_top (
      .ctl_clk (ctl_clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .sdi     (sdi),
      .ch_sel  (ch_sel),
      .mode_sel(mode_sel),
      .fs_en   (fs_en),
      .fs_slot (fs_slot)
   );

   task automatic compare(input string req);
      logic [7:0]  ee;
      logic [47:0] es;
      for (int o = 0; o < 8; o++) begin
         ee[o]          = exp_en[o];
         es[o*6 +: 6]   = exp_slot[o];
      end
      checks++;
      if (fs_en !== ee || fs_slot !== es) begin
         errors++;
         $display("FAIL %s: en=%b slot=%h expected en=%b slot=%h", req, fs_en, fs_slot, ee, es);
      end
   endtask

   // Model of a committed 8-bit word
   task automatic model(input logic [7:0] w, input logic [2:0] c, input logic m);
      logic [1:0] xr = w[7:6];
      logic [5:0] s  = w[5:0];
      if (m) begin
         int ch = int'(c[1:0]);
         if (xr != 2'b10) begin exp_en[ch] = 1'b1; exp_slot[ch] = s; end
         if (xr != 2'b01) begin exp_en[ch+4] = 1'b1; exp_slot[ch+4] = s; end
      end else begin
         int n = int'(c);
         if (xr == 2'b11) exp_en[n] = 1'b0;
         else begin exp_en[n] = 1'b1; exp_slot[n] = s; end
      end
   endtask

   task automatic send(input logic [7:0] w, input logic [2:0] c, input logic m,
                       input int nbits, input bit late, input string req);
      @(negedge ctl_clk);
      cs_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         sdi      = (i < 8) ? w[7-i] : i[0];
         ch_sel   = c;
         mode_sel = m;
         @(posedge ctl_clk);
         @(negedge ctl_clk);
      end
      compare({req, " R3 hold before release"});
      if (late) begin
         ch_sel   = ~c;
         mode_sel = ~m;
      end
      cs_n = 1'b1;
      @(posedge ctl_clk);
      @(negedge ctl_clk);
      if (nbits == 8) model(w, c, m);
      compare(req);
   endtask

   initial begin
      #(20ns * 200000);
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int o = 0; o < 8; o++) begin exp_en[o] = 1'b0; exp_slot[o] = '0; end
      repeat (3) @(negedge ctl_clk);
      rst_n = 1'b1;
      @(negedge ctl_clk);
      compare("R1 reset state");

      // R5 R6 R10: mode 1, all channel codes (ch_sel[2] ignored) and direction codes
      for (int c = 0; c < 8; c++)
         for (int xr = 0; xr < 4; xr++)
            send({xr[1:0], 6'((c*17 + xr*5 + 3) % 64)}, c[2:0], 1'b1, 8, 1'b0, "R5/R6/R10 mode1");

      // R7 R8 R10: mode 2, every output and direction code
      for (int c = 0; c < 8; c++)
         for (int xr = 0; xr < 4; xr++)
            send({xr[1:0], 6'((c*11 + xr*23 + 7) % 64)}, c[2:0], 1'b0, 8, 1'b0, "R7/R8 mode2");

      // R8: disable keeps slot, re-enable then disable again
      send({2'b00, 6'd42}, 3'd6, 1'b0, 8, 1'b0, "R7 assign");
      send({2'b11, 6'd5},  3'd6, 1'b0, 8, 1'b0, "R8 off keeps slot");

      // R11 R2: every slot value on output 5, and on output 2 via mode 1 transmit
      for (int s = 0; s < 64; s++) begin
         send({2'b01, s[5:0]}, 3'd5, 1'b0, 8, 1'b0, "R11/R2 slot sweep mode2");
         send({2'b01, 6'(63 - s)}, 3'd2, 1'b1, 8, 1'b0, "R11/R2 slot sweep mode1");
      end

      // R4: wrong frame lengths
      send({2'b00, 6'd9}, 3'd1, 1'b1, 0,  1'b0, "R4 zero bits");
      send({2'b00, 6'd9}, 3'd1, 1'b1, 1,  1'b0, "R4 one bit");
      send({2'b00, 6'd9}, 3'd1, 1'b1, 7,  1'b0, "R4 seven bits");
      send({2'b00, 6'd9}, 3'd1, 1'b1, 9,  1'b0, "R4 nine bits");
      send({2'b10, 6'd9}, 3'd3, 1'b0, 12, 1'b0, "R4 twelve bits");

      // R9: pins change after the eighth bit
      send({2'b01, 6'd33}, 3'd0, 1'b1, 8, 1'b1, "R9 late pin change mode1");
      send({2'b00, 6'd17}, 3'd3, 1'b0, 8, 1'b1, "R9 late pin change mode2");

      // R1 again: reset clears after programming
      rst_n = 1'b0;
      @(negedge ctl_clk);
      rst_n = 1'b1;
      for (int o = 0; o < 8; o++) begin exp_en[o] = 1'b0; exp_slot[o] = '0; end
      @(negedge ctl_clk);
      compare("R1 reset after use");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule